// File: doc/BRIEF.md
# Sequential Ones Counter

This block counts the set bits of a data word one bit per clock. A start request captures the word into a shift register and clears a result counter. On every following cycle the controller looks at the remaining word. If it is still non-zero, the counter adds the lowest bit and the word moves one place to the right. Once the remaining word is zero, the run ends and the block raises its completion flag.

The run length therefore follows the position of the highest set bit, not the word width. An all-zero word finishes almost at once. The controller is a Mealy machine: the step enable depends on the live zero test of the remaining word as well as on the state. The completion flag stays up for as long as the request is held. Once the request drops, the block returns to idle and keeps the count on its output.

Top module: `bitweight_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` is 0 and `count` is 0.
- R2: A rising clock edge in idle with `start` high captures `din` into the working word and sets `count` to 0.
- R3: Each cycle in which the working word is non-zero, `count` grows by the word's bit 0 and the word shifts right by one place.
- R4: With h the index of the highest set bit of the captured word, `done` is first seen high after the (h+3)-th rising edge, counting the edge that sampled `start` as the first.
- R5: An all-zero captured word gives `done` after the 2nd edge, with `count` equal to 0.
- R6: `count` is `$clog2(WIDTH)+1` bits wide, so an all-ones word yields exactly WIDTH.
- R7: `done` stays high while `start` is held high and drops one edge after `start` is low.
- R8: `count` holds its final value after `done` falls and until the next start is accepted.
- R9: Changes on `din` after the capturing edge have no effect on the running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; held high until done is seen |
| din | input | WIDTH | Word whose set bits are counted |
| count | output | $clog2(WIDTH)+1 | Number of set bits |
| done | output | 1 | Run complete, result valid |

## Verification
The bench aims at the early-exit rule. It measures the latency for words whose top set bit lies at different places. A design that always ran WIDTH iterations, or stopped one step early or late, would miss the expected cycle. The all-zero word and the all-ones word test both ends of the count: a counter that is too narrow wraps to zero on all ones, and an exit test placed after the first step would stretch the zero case. Further cases check that `din` can change in the middle of a run without effect, that `done` stays up while `start` is held, and that `count` survives the return to idle. A design that re-captured the word, lost the handshake or cleared the result in idle would fail these.

// File: rtl/bitweight_pkg.sv
package bitweight_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bw_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } bw_ctrl_t;

    function automatic int count_bits(input int width);
        return $clog2(width) + 1;
    endfunction

endpackage

// File: rtl/bw_datapath.sv
module bw_datapath
    import bitweight_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CW   = count_bits(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  bw_ctrl_t         ctl,
    input  logic [WIDTH-1:0] din,
    output logic             word_zero,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] word_q;
    logic [CW-1:0]    inc;

    assign inc       = {{(CW-1){1'b0}}, word_q[0]};
    assign word_zero = (word_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            count  <= '0;
        end else if (ctl.load) begin
            word_q <= din;
            count  <= '0;
        end else if (ctl.step) begin
            word_q <= word_q >> 1;
            count  <= count + inc;
        end
    end

    a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (count == '0) && (word_q == $past(din)));

    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        ctl.step |=> word_q == ($past(word_q) >> 1));

    a_r3_accumulate: assert property (@(posedge clk) disable iff (rst)
        ctl.step |=> count == $past(count) + CW'($past(word_q[0])));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(WIDTH));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.step) |=> $stable(count));

endmodule

// File: rtl/bw_control.sv
module bw_control
    import bitweight_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     word_zero,
    output bw_ctrl_t ctl,
    output logic     done
);

    bw_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        ctl.load = 1'b0;
        ctl.step = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                ctl.load = 1'b1;
                state_d  = ST_RUN;
            end
            ST_RUN: begin
                if (word_zero) state_d  = ST_FIN;
                else           ctl.step = 1'b1;
            end
            ST_FIN: if (!start) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign done = (state_q == ST_FIN);

    a_r4_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && word_zero) |=> done);

    a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> done);

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !ctl.load);

endmodule

// File: rtl/bitweight_seq.sv
module bitweight_seq
    import bitweight_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CW   = count_bits(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] din,
    output logic [CW-1:0]    count,
    output logic             done
);

    bw_ctrl_t ctl;
    logic     word_zero;

    bw_control u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .word_zero (word_zero),
        .ctl       (ctl),
        .done      (done)
    );

    bw_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .din       (din),
        .word_zero (word_zero),
        .count     (count)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!done && count == '0));

endmodule

// File: tb/bitweight_seq_bench.sv
module bitweight_seq_bench;
    localparam int WIDTH  = 8;
    localparam int CW     = $clog2(WIDTH) + 1;
    localparam time CLK_T = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [CW-1:0]    count;
    logic             done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_T/2) clk = ~clk;

    bitweight_seq #(.WIDTH(WIDTH)) u_bitweight_seq (
        .clk(clk), .rst(rst), .start(start), .din(din),
        .count(count), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [WIDTH-1:0] v);
        int n = 0;
        for (int i = 0; i < WIDTH; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int expect_lat(input logic [WIDTH-1:0] v);
        int h = -1;
        for (int i = 0; i < WIDTH; i++) if (v[i]) h = i;
        return (h < 0) ? 2 : h + 3;
    endfunction

    task automatic run_case(input string req, input logic [WIDTH-1:0] v,
                            input bit scramble);
        int cyc = 0;
        @(negedge clk);
        din   = v;
        start = 1'b1;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done || cyc > 4 * WIDTH) break;
            if (scramble) din = ~din;
        end
        check({req, " count"}, int'(count), ones(v));
        check({req, " latency (R4)"}, cyc, expect_lat(v));
        repeat (3) @(negedge clk);
        check("R7 done held while start high", int'(done), 1);
        start = 1'b0;
        din   = 8'h5A;
        @(negedge clk);
        check("R7 done drops after release", int'(done), 0);
        @(negedge clk);
        check("R8 count kept in idle", int'(count), ones(v));
    endtask

    task automatic reset_case();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 done in reset", int'(done), 0);
        check("R1 count in reset", int'(count), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
    endtask

    task automatic load_case();
        @(negedge clk);
        din   = 8'hF0;
        start = 1'b1;
        @(negedge clk);
        check("R2 count cleared on capture", int'(count), 0);
        wait (done);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_T * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        reset_case();
        run_case("R5 zero word", 8'h00, 1'b0);
        run_case("R6 all ones", 8'hFF, 1'b0);
        run_case("R3 single low bit", 8'h01, 1'b0);
        run_case("R4 single top bit", 8'h80, 1'b0);
        run_case("R3 mixed pattern", 8'hA5, 1'b0);
        run_case("R4 middle bit", 8'h10, 1'b0);
        run_case("R9 din changes mid run", 8'h36, 1'b1);
        load_case();
        run_case("R3 sparse pattern", 8'h42, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule